// File: doc/BRIEF.md
# Multiphase Framed Serial Receiver

This block is the receive side of a synchronous time-division serial port. The bit clock arrives as a one-cycle strobe, `bit_tick`, synchronous to the system clock. Serial data and frame sync are sampled only on that strobe. A frame begins with a frame-sync pulse. After a selectable delay, words are shifted in with a programmable size. The block counts words per frame and can split the frame into two phases, each with its own word size and word count.

Each completed word passes through a three-stage buffer: a holding register behind the shifter, a buffer register, and the receive register that software reads. On its way into the receive register the word is justified. The block raises ready, full and sync-error status and one selectable interrupt. In multichannel mode a 128-bit mask picks which time slots are stored. Slots that are not picked still count toward frame timing. All configuration comes in as static inputs.

Top module: `rx_frame_port`

## Requirements
- R1: The word-size code maps 0, 1, 2, 3, 4 and 5 to 8, 12, 16, 20, 24 and 32 bits. When the companding code is 0, words are received MSB first.
- R2: The justification code controls how a word is placed in `rdata`. Code 0 right-aligns it with zeros above. Code 1 right-aligns it and copies its top bit into the unused upper bits. Code 2 puts the word in the top bits with zeros below. Code 3 behaves like code 0.
- R3: With data delay code 0, the first data bit is the bit sampled together with the frame sync. Code 1 starts one tick later and code 2 starts two ticks later. Code 3 behaves like code 2.
- R4: A frame-length field holding N gives N+1 words in that phase. When `dual_phase`=1, phase two follows phase one and uses `flen2`/`wlen2`. When `dual_phase`=0, phase two's fields have no effect and the frame ends after phase one.
- R5: Companding code 1 receives 8-bit words LSB first. Codes 2 and 3 receive 8-bit words MSB first, passed unexpanded. For codes 1 to 3 the word-size code is ignored.
- R6: A sync sampled during a frame (including its delay ticks) is unexpected. With `fs_ignore`=0 it sets a sticky `sync_err` and restarts the frame from that pulse. With `fs_ignore`=1 the pulse is discarded, and that tick's data bit is kept as normal.
- R7: `full` is high when the holding, buffer and receive registers all hold unread words. A word that completes while the holding register is occupied is lost.
- R8: `ready` rises when a word reaches `rdata`, and `rdata` stays stable while `ready` is high and no read occurs. A one-cycle `rd` clears `ready`. The next buffered word lands one clock later.
- R9: When `mc_en`=1, slot k (counted from 0 through both phases) is stored only if `chan_mask[k]`=1. Slots numbered 128 and above are never stored. When `mc_en`=0 every slot is stored.
- R10: `irq_sel` 0 makes `irq` follow `ready`. Codes 1, 2 and 3 give a one-cycle `irq` pulse: code 1 after every 16th slot, code 2 on each accepted frame sync, and code 3 when a sync error is flagged.
- R11: After reset, and whenever `rx_en`=0, counters, buffers and flags are clear (`ready`, `full`, `sync_err`, `irq` low; `rdata` 0 after reset). While `rx_en`=0, serial activity is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low holds the receiver cleared |
| bit_tick | input | 1 | One-cycle bit-clock sampling strobe |
| fsync | input | 1 | Frame sync, active high, sampled on `bit_tick` |
| sdi | input | 1 | Serial data, sampled on `bit_tick` |
| dual_phase | input | 1 | 1 selects a two-phase frame |
| flen1 | input | 7 | Phase-one word count minus one |
| flen2 | input | 7 | Phase-two word count minus one |
| wlen1 | input | 3 | Phase-one word-size code |
| wlen2 | input | 3 | Phase-two word-size code |
| data_dly | input | 2 | Sync-to-data delay code |
| just_mode | input | 2 | Justification code |
| cmp_mode | input | 2 | Companding / bit-order code |
| fs_ignore | input | 1 | Discard unexpected frame syncs |
| mc_en | input | 1 | Multichannel slot selection enable |
| chan_mask | input | 128 | Per-slot store enable |
| irq_sel | input | 2 | Interrupt source select |
| rd | input | 1 | Read strobe for `rdata` |
| rdata | output | 32 | Justified receive word |
| ready | output | 1 | Unread word in `rdata` |
| full | output | 1 | All three buffer stages occupied |
| sync_err | output | 1 | Sticky unexpected-sync flag |
| irq | output | 1 | Selected interrupt |

## Verification
Bit-counter or phase errors in the sequencer show up at the ports in two ways. The word in `rdata` is shifted or truncated. Or the next legitimate sync raises `sync_err`, because the frame was still open when it should have ended. Both appear within one frame. A stale valid bit in the buffer shows as `full` asserted too early, or as an extra or missing word once the stored words are read back. The slot counter feeds both the channel mask and the 16-slot interrupt, so an off-by-one there shows as the wrong word surviving the mask, or a misplaced `irq` pulse, a few words into a frame.

// File: rtl/rx_frame_pkg.sv
package rx_frame_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SKIP = 2'd1,
    ST_DATA = 2'd2
  } rx_state_e;

  // word-size code to bit count; reserved codes fall back to the widest word
  function automatic logic [5:0] wl_bits(input logic [2:0] code);
    case (code)
      3'd0:    wl_bits = 6'd8;
      3'd1:    wl_bits = 6'd12;
      3'd2:    wl_bits = 6'd16;
      3'd3:    wl_bits = 6'd20;
      3'd4:    wl_bits = 6'd24;
      default: wl_bits = 6'd32;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] low_mask(input logic [5:0] n);
    if (n >= 6'(WORD_W)) low_mask = '1;
    else                 low_mask = (WORD_W'(1) << n) - WORD_W'(1);
  endfunction

  // place a right-aligned word of code-given size into the receive register
  function automatic logic [WORD_W-1:0] justify(input logic [WORD_W-1:0] w,
                                                input logic [2:0] code,
                                                input logic [1:0] mode);
    logic [5:0]        n;
    logic [WORD_W-1:0] m;
    logic [WORD_W-1:0] z;
    n = wl_bits(code);
    m = low_mask(n);
    z = w & m;
    case (mode)
      2'd1:    justify = z[n-6'd1] ? (z | ~m) : z;
      2'd2:    justify = z << (6'(WORD_W) - n);
      default: justify = z;
    endcase
  endfunction

endpackage

// File: rtl/rx_frame_seq.sv
module rx_frame_seq
  import rx_frame_pkg::*;
#(
  parameter int FLEN_W = 7,
  localparam int SLOT_W = FLEN_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_en,
  input  logic                bit_tick,
  input  logic                fsync,
  input  logic                sdi,
  input  logic                dual_phase,
  input  logic [FLEN_W-1:0]   flen1,
  input  logic [FLEN_W-1:0]   flen2,
  input  logic [2:0]          wlen1,
  input  logic [2:0]          wlen2,
  input  logic [1:0]          data_dly,
  input  logic [1:0]          cmp_mode,
  input  logic                fs_ignore,
  output logic                word_done,
  output logic [WORD_W-1:0]   word_data,
  output logic [2:0]          word_code,
  output logic [SLOT_W-1:0]   word_slot,
  output logic                frame_start,
  output logic                sync_bad
);

  rx_state_e            state_q, state_d;
  logic [5:0]           bit_q, bit_d;
  logic [FLEN_W-1:0]    wrd_q, wrd_d;
  logic                 ph_q, ph_d;
  logic [SLOT_W-1:0]    slot_q, slot_d;
  logic [WORD_W-1:0]    sreg_q, sreg_d;

  logic                 tick, hit, restart, capture, lsb_first;
  logic [5:0]           cur_b, nbits;
  logic [FLEN_W-1:0]    cur_w, flen_cur;
  logic                 cur_ph;
  logic [SLOT_W-1:0]    cur_sl;
  logic [2:0]           code;
  logic [WORD_W-1:0]    shifted;

  assign tick      = rx_en & bit_tick;
  assign hit       = tick & fsync;
  assign lsb_first = (cmp_mode == 2'd1);

  always_comb begin
    state_d     = state_q;
    bit_d       = bit_q;
    wrd_d       = wrd_q;
    ph_d        = ph_q;
    slot_d      = slot_q;
    sreg_d      = sreg_q;
    word_done   = 1'b0;
    word_data   = '0;
    word_code   = '0;
    word_slot   = '0;
    frame_start = 1'b0;
    sync_bad    = 1'b0;
    restart     = 1'b0;
    capture     = 1'b0;

    // classify this tick
    if (state_q == ST_IDLE) begin
      restart = hit;
    end else if (hit && !fs_ignore) begin
      restart  = 1'b1;
      sync_bad = 1'b1;
    end else if (tick) begin
      if (state_q == ST_DATA) capture = 1'b1;
      else                    state_d = ST_DATA;
    end

    // frame (re)start: counters from zero, delay picks the first data tick
    if (restart) begin
      frame_start = 1'b1;
      bit_d  = '0;
      wrd_d  = '0;
      ph_d   = 1'b0;
      slot_d = '0;
      case (data_dly)
        2'd0:    begin state_d = ST_DATA; capture = 1'b1; end
        2'd1:    state_d = ST_DATA;
        default: state_d = ST_SKIP;
      endcase
    end

    cur_b    = restart ? 6'd0 : bit_q;
    cur_w    = restart ? '0 : wrd_q;
    cur_ph   = restart ? 1'b0 : ph_q;
    cur_sl   = restart ? '0 : slot_q;
    code     = (cmp_mode != 2'd0) ? 3'd0 : (cur_ph ? wlen2 : wlen1);
    nbits    = wl_bits(code);
    flen_cur = cur_ph ? flen2 : flen1;
    shifted  = lsb_first ? {sdi, sreg_q[WORD_W-1:1]} : {sreg_q[WORD_W-2:0], sdi};

    if (capture) begin
      sreg_d = shifted;
      if (cur_b + 6'd1 == nbits) begin
        word_done = 1'b1;
        word_code = code;
        word_slot = cur_sl;
        word_data = lsb_first ? (shifted >> (6'(WORD_W) - nbits))
                              : (shifted & low_mask(nbits));
        bit_d  = '0;
        slot_d = cur_sl + SLOT_W'(1);
        if (cur_w == flen_cur) begin
          wrd_d = '0;
          if (!cur_ph && dual_phase) begin
            ph_d = 1'b1;
          end else begin
            ph_d    = 1'b0;
            state_d = ST_IDLE;
          end
        end else begin
          wrd_d = cur_w + FLEN_W'(1);
        end
      end else begin
        bit_d = cur_b + 6'd1;
      end
    end

    if (!rx_en) begin
      state_d = ST_IDLE;
      bit_d   = '0;
      wrd_d   = '0;
      ph_d    = 1'b0;
      slot_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      wrd_q   <= '0;
      ph_q    <= 1'b0;
      slot_q  <= '0;
      sreg_q  <= '0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      wrd_q   <= wrd_d;
      ph_q    <= ph_d;
      slot_q  <= slot_d;
      sreg_q  <= sreg_d;
    end
  end

endmodule

// File: rtl/rx_frame_buf.sv
module rx_frame_buf
  import rx_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [2:0]        wcode,
  input  logic [1:0]        just_mode,
  input  logic              rd,
  output logic [WORD_W-1:0] rdata,
  output logic              ready,
  output logic              full
);

  logic              hold_v_q, hold_v_d;
  logic [WORD_W-1:0] hold_q, hold_d;
  logic [2:0]        hold_c_q, hold_c_d;
  logic              buf_v_q, buf_v_d;
  logic [WORD_W-1:0] buf_q, buf_d;
  logic [2:0]        buf_c_q, buf_c_d;
  logic [WORD_W-1:0] out_q, out_d;
  logic              rdy_q, rdy_d;
  logic              ld_hold, mv_buf, mv_out;

  assign ld_hold = wr && !hold_v_q;
  assign mv_buf  = hold_v_q && !buf_v_q;
  assign mv_out  = buf_v_q && !rdy_q;

  always_comb begin
    hold_v_d = hold_v_q;
    hold_d   = hold_q;
    hold_c_d = hold_c_q;
    buf_v_d  = buf_v_q;
    buf_d    = buf_q;
    buf_c_d  = buf_c_q;
    out_d    = out_q;
    rdy_d    = rdy_q;

    if (mv_buf) begin
      buf_v_d  = 1'b1;
      buf_d    = hold_q;
      buf_c_d  = hold_c_q;
      hold_v_d = 1'b0;
    end
    if (ld_hold) begin
      hold_v_d = 1'b1;
      hold_d   = wdata;
      hold_c_d = wcode;
    end
    if (mv_out) begin
      out_d   = justify(buf_q, buf_c_q, just_mode);
      rdy_d   = 1'b1;
      buf_v_d = mv_buf;
    end else if (rd) begin
      rdy_d = 1'b0;
    end

    if (!rx_en) begin
      hold_v_d = 1'b0;
      buf_v_d  = 1'b0;
      rdy_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v_q <= 1'b0;
      hold_q   <= '0;
      hold_c_q <= '0;
      buf_v_q  <= 1'b0;
      buf_q    <= '0;
      buf_c_q  <= '0;
      out_q    <= '0;
      rdy_q    <= 1'b0;
    end else begin
      hold_v_q <= hold_v_d;
      hold_q   <= hold_d;
      hold_c_q <= hold_c_d;
      buf_v_q  <= buf_v_d;
      buf_q    <= buf_d;
      buf_c_q  <= buf_c_d;
      out_q    <= out_d;
      rdy_q    <= rdy_d;
    end
  end

  assign rdata = out_q;
  assign ready = rdy_q;
  assign full  = hold_v_q && buf_v_q && rdy_q;

endmodule

// File: rtl/rx_frame_stat.sv
module rx_frame_stat #(
  parameter int SLOT_W  = 8,
  parameter int IRQ_BLK = 16,
  localparam int BLK_W  = $clog2(IRQ_BLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic [1:0]        irq_sel,
  input  logic              ready,
  input  logic              word_done,
  input  logic [SLOT_W-1:0] word_slot,
  input  logic              frame_start,
  input  logic              sync_bad,
  output logic              sync_err,
  output logic              irq
);

  logic err_q, err_d;
  logic ev_q, ev_d;
  logic blk_end;

  generate
    if (BLK_W > 0) begin : g_blk
      assign blk_end = word_done && (word_slot[BLK_W-1:0] == {BLK_W{1'b1}});
    end else begin : g_every
      assign blk_end = word_done;
    end
  endgenerate

  always_comb begin
    err_d = err_q | sync_bad;
    case (irq_sel)
      2'd1:    ev_d = blk_end;
      2'd2:    ev_d = frame_start;
      2'd3:    ev_d = sync_bad;
      default: ev_d = 1'b0;
    endcase
    if (!rx_en) begin
      err_d = 1'b0;
      ev_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      ev_q  <= 1'b0;
    end else begin
      err_q <= err_d;
      ev_q  <= ev_d;
    end
  end

  assign sync_err = err_q;
  assign irq      = (irq_sel == 2'd0) ? ready : ev_q;

endmodule

// File: rtl/rx_frame_port.sv
module rx_frame_port
  import rx_frame_pkg::*;
#(
  parameter int FLEN_W  = 7,
  parameter int SLOTS   = 128,
  parameter int IRQ_BLK = 16,
  localparam int SLOT_W = FLEN_W + 1,
  localparam int SIDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              bit_tick,
  input  logic              fsync,
  input  logic              sdi,
  input  logic              dual_phase,
  input  logic [FLEN_W-1:0] flen1,
  input  logic [FLEN_W-1:0] flen2,
  input  logic [2:0]        wlen1,
  input  logic [2:0]        wlen2,
  input  logic [1:0]        data_dly,
  input  logic [1:0]        just_mode,
  input  logic [1:0]        cmp_mode,
  input  logic              fs_ignore,
  input  logic              mc_en,
  input  logic [SLOTS-1:0]  chan_mask,
  input  logic [1:0]        irq_sel,
  input  logic              rd,
  output logic [WORD_W-1:0] rdata,
  output logic              ready,
  output logic              full,
  output logic              sync_err,
  output logic              irq
);

  logic              word_done, frame_start, sync_bad, slot_on;
  logic [WORD_W-1:0] word_data;
  logic [2:0]        word_code;
  logic [SLOT_W-1:0] word_slot;

  rx_frame_seq #(.FLEN_W(FLEN_W)) i_seq (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_tick(bit_tick),
    .fsync(fsync), .sdi(sdi), .dual_phase(dual_phase),
    .flen1(flen1), .flen2(flen2), .wlen1(wlen1), .wlen2(wlen2),
    .data_dly(data_dly), .cmp_mode(cmp_mode), .fs_ignore(fs_ignore),
    .word_done(word_done), .word_data(word_data), .word_code(word_code),
    .word_slot(word_slot), .frame_start(frame_start), .sync_bad(sync_bad)
  );

  // slot gate: out-of-range slots are never stored in multichannel mode
  assign slot_on = !mc_en ||
                   ((32'(word_slot) < SLOTS) && chan_mask[word_slot[SIDX_W-1:0]]);

  rx_frame_buf i_buf (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
    .wr(word_done && slot_on), .wdata(word_data), .wcode(word_code),
    .just_mode(just_mode), .rd(rd),
    .rdata(rdata), .ready(ready), .full(full)
  );

  rx_frame_stat #(.SLOT_W(SLOT_W), .IRQ_BLK(IRQ_BLK)) i_stat (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .irq_sel(irq_sel),
    .ready(ready), .word_done(word_done), .word_slot(word_slot),
    .frame_start(frame_start), .sync_bad(sync_bad),
    .sync_err(sync_err), .irq(irq)
  );

endmodule

// File: rtl/rx_frame_chk.sv
module rx_frame_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_en,
  input logic        fs_ignore,
  input logic        rd,
  input logic [31:0] rdata,
  input logic        ready,
  input logic        full,
  input logic        sync_err
);

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    full && !rd && rx_en |=> full); // R7

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd && ready |=> !ready); // R8

  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !rd && rx_en |=> ready && $stable(rdata)); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err && rx_en |=> sync_err); // R6

  AST_IGNORE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    fs_ignore && rx_en && !sync_err |=> !sync_err); // R6

  AST_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !ready && !full && !sync_err); // R11

endmodule

bind rx_frame_port rx_frame_chk i_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .fs_ignore(fs_ignore),
  .rd(rd), .rdata(rdata), .ready(ready), .full(full), .sync_err(sync_err)
);

// File: tb/test_rx_frame_port.sv
`timescale 1ns/1ps
module test_rx_frame_port;

  logic         clk, rst_n, rx_en, bit_tick, fsync, sdi;
  logic         dual_phase, fs_ignore, mc_en, rd;
  logic [6:0]   flen1, flen2;
  logic [2:0]   wlen1, wlen2;
  logic [1:0]   data_dly, just_mode, cmp_mode, irq_sel;
  logic [127:0] chan_mask;
  logic [31:0]  rdata;
  logic         ready, full, sync_err, irq;

  int n_chk = 0;
  int n_bad = 0;
  int irq_cnt = 0;
  bit done = 0;

  rx_frame_port i_rx_frame_port (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_tick(bit_tick),
    .fsync(fsync), .sdi(sdi), .dual_phase(dual_phase),
    .flen1(flen1), .flen2(flen2), .wlen1(wlen1), .wlen2(wlen2),
    .data_dly(data_dly), .just_mode(just_mode), .cmp_mode(cmp_mode),
    .fs_ignore(fs_ignore), .mc_en(mc_en), .chan_mask(chan_mask),
    .irq_sel(irq_sel), .rd(rd), .rdata(rdata), .ready(ready),
    .full(full), .sync_err(sync_err), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) if (irq === 1'b1) irq_cnt <= irq_cnt + 1;

  // fields: wlen[72:70] just[69:68] cmp[67:66] dly[65:64] data[63:32] expected[31:0]
  localparam logic [72:0] VEC [11] = '{
    {3'd0, 2'd0, 2'd0, 2'd1, 32'h000000A5, 32'h000000A5},
    {3'd0, 2'd1, 2'd0, 2'd1, 32'h000000A5, 32'hFFFFFFA5},
    {3'd0, 2'd2, 2'd0, 2'd0, 32'h000000A5, 32'hA5000000},
    {3'd1, 2'd1, 2'd0, 2'd2, 32'h000007F3, 32'h000007F3},
    {3'd1, 2'd1, 2'd0, 2'd0, 32'h000009A5, 32'hFFFFF9A5},
    {3'd2, 2'd0, 2'd0, 2'd0, 32'h0000BEEF, 32'h0000BEEF},
    {3'd3, 2'd1, 2'd0, 2'd1, 32'h00081234, 32'hFFF81234},
    {3'd4, 2'd2, 2'd0, 2'd1, 32'h00C0FFEE, 32'hC0FFEE00},
    {3'd5, 2'd0, 2'd0, 2'd2, 32'hDEADBEEF, 32'hDEADBEEF},
    {3'd2, 2'd0, 2'd1, 2'd1, 32'h0000001D, 32'h0000001D},
    {3'd5, 2'd1, 2'd2, 2'd1, 32'h00000081, 32'hFFFFFF81}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic b, input logic fs);
    @(negedge clk); sdi = b; fsync = fs; bit_tick = 1'b1;
    @(negedge clk); bit_tick = 1'b0; fsync = 1'b0;
  endtask

  task automatic word_out(input logic [31:0] d, input int n, input bit lsb, input int fs_at);
    for (int i = 0; i < n; i++) bit_out(lsb ? d[i] : d[n-1-i], i == fs_at);
  endtask

  task automatic frame_hdr(input int dl);
    if (dl > 0) begin
      bit_out(1'b0, 1'b1);
      for (int i = 1; i < dl; i++) bit_out(1'b0, 1'b0);
    end
  endtask

  task automatic settle;
    repeat (6) @(negedge clk);
  endtask

  task automatic read_word;
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic flush;
    @(negedge clk); rx_en = 1'b0;
    repeat (2) @(negedge clk); rx_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; rx_en = 1'b0; bit_tick = 1'b0; fsync = 1'b0; sdi = 1'b0;
    dual_phase = 1'b0; fs_ignore = 1'b0; mc_en = 1'b0; rd = 1'b0;
    flen1 = '0; flen2 = '0; wlen1 = '0; wlen2 = '0;
    data_dly = 2'd1; just_mode = '0; cmp_mode = '0; irq_sel = '0;
    chan_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 rdata reset", rdata, 32'h0);
    chk("R11 flags reset", {28'h0, ready, full, sync_err, irq}, 32'h0);
    rx_en = 1'b1;
    @(negedge clk);

    // vector table: R1 R2 R3 R5
    for (int v = 0; v < 11; v++) begin
      int n;
      logic [72:0] e;
      e = VEC[v];
      @(negedge clk);
      wlen1 = e[72:70]; just_mode = e[69:68]; cmp_mode = e[67:66]; data_dly = e[65:64];
      flen1 = '0; dual_phase = 1'b0;
      if (e[67:66] != 2'd0) n = 8;
      else case (e[72:70])
        3'd0: n = 8; 3'd1: n = 12; 3'd2: n = 16;
        3'd3: n = 20; 3'd4: n = 24; default: n = 32;
      endcase
      frame_hdr(int'(e[65:64]));
      word_out(e[63:32], n, e[67:66] == 2'd1, (e[65:64] == 2'd0) ? 0 : -1);
      settle();
      chk($sformatf("R1/R2/R3/R5 vec%0d ready", v), {31'h0, ready}, 32'h1);
      chk($sformatf("R1/R2/R3/R5 vec%0d rdata", v), rdata, e[31:0]);
      read_word();
      chk($sformatf("R8 vec%0d ready after read", v), {31'h0, ready}, 32'h0);
    end
    chk("R6 no error after table", {31'h0, sync_err}, 32'h0);

    // R4 R7 dual phase: 2 x 8-bit then 1 x 16-bit; second frame is lost
    @(negedge clk);
    dual_phase = 1'b1; flen1 = 7'd1; flen2 = 7'd0; wlen1 = 3'd0; wlen2 = 3'd2;
    data_dly = 2'd1; just_mode = 2'd0; cmp_mode = 2'd0;
    for (int f = 0; f < 2; f++) begin
      frame_hdr(1);
      word_out(32'h11, 8, 1'b0, -1);
      word_out(32'h22, 8, 1'b0, -1);
      word_out(32'h3344, 16, 1'b0, -1);
      settle();
      if (f == 0) chk("R7 full after three words", {31'h0, full}, 32'h1);
    end
    chk("R4 no sync error across dual frames", {31'h0, sync_err}, 32'h0);
    chk("R4 dual word0", rdata, 32'h11);
    read_word();
    chk("R7 full drops after read", {31'h0, full}, 32'h0);
    chk("R8 dual word1", rdata, 32'h22);
    read_word();
    chk("R4 dual phase-two word", rdata, 32'h3344);
    read_word();
    chk("R7 overflowed frame lost", {31'h0, ready}, 32'h0);

    // R4 single phase ignores phase-two fields
    @(negedge clk);
    dual_phase = 1'b0; flen1 = 7'd1; flen2 = 7'd5; wlen2 = 3'd5;
    frame_hdr(1);
    word_out(32'h5A, 8, 1'b0, -1);
    word_out(32'hC3, 8, 1'b0, -1);
    settle();
    chk("R4 single word0", rdata, 32'h5A);
    read_word();
    chk("R4 single word1", rdata, 32'hC3);
    read_word();
    frame_hdr(1);
    word_out(32'h66, 8, 1'b0, -1);
    word_out(32'h77, 8, 1'b0, -1);
    settle();
    chk("R4 next sync is expected", {31'h0, sync_err}, 32'h0);
    chk("R4 next frame word", rdata, 32'h66);
    read_word(); read_word();

    // R6 ignore: sync in mid-word discarded, word intact
    @(negedge clk);
    flen1 = 7'd0; fs_ignore = 1'b1;
    frame_hdr(1);
    word_out(32'h96, 8, 1'b0, 4);
    settle();
    chk("R6 ignored sync no error", {31'h0, sync_err}, 32'h0);
    chk("R6 ignored sync word intact", rdata, 32'h96);
    read_word();

    // R6 R10 error flagged, irq code 3 pulses once
    @(negedge clk);
    fs_ignore = 1'b0; irq_sel = 2'd3; flen1 = 7'd1;
    @(negedge clk); irq_cnt = 0;
    frame_hdr(1);
    word_out(32'h96, 8, 1'b0, 4);
    settle();
    chk("R6 unexpected sync flagged", {31'h0, sync_err}, 32'h1);
    chk("R10 sync-error irq count", irq_cnt, 32'd1);
    flush();
    chk("R11 rx_en clears error", {31'h0, sync_err}, 32'h0);

    // R10 frame-sync irq
    @(negedge clk); irq_sel = 2'd2; flen1 = 7'd0; irq_cnt = 0;
    frame_hdr(1);
    word_out(32'h12, 8, 1'b0, -1);
    settle();
    chk("R10 frame-sync irq count", irq_cnt, 32'd1);
    flush();

    // R10 every-16-slots irq
    @(negedge clk); irq_sel = 2'd1; flen1 = 7'd15; irq_cnt = 0;
    frame_hdr(1);
    for (int k = 0; k < 16; k++) word_out(32'(k), 8, 1'b0, -1);
    settle();
    chk("R10 16-slot irq count", irq_cnt, 32'd1);
    flush();

    // R9 multichannel: slots 1 and 3 only
    @(negedge clk);
    irq_sel = 2'd0; flen1 = 7'd3; mc_en = 1'b1;
    chan_mask = '0; chan_mask[1] = 1'b1; chan_mask[3] = 1'b1;
    frame_hdr(1);
    word_out(32'hA1, 8, 1'b0, -1);
    word_out(32'hA2, 8, 1'b0, -1);
    word_out(32'hA3, 8, 1'b0, -1);
    word_out(32'hA4, 8, 1'b0, -1);
    settle();
    chk("R9 first enabled slot", rdata, 32'hA2);
    chk("R10 irq follows ready", {31'h0, irq}, 32'h1);
    read_word();
    chk("R9 second enabled slot", rdata, 32'hA4);
    read_word();
    chk("R9 masked slots not stored", {31'h0, ready}, 32'h0);
    chk("R10 irq low with ready low", {31'h0, irq}, 32'h0);
    mc_en = 1'b0;

    // R11 disabled receiver ignores traffic and clears a pending word
    @(negedge clk); flen1 = 7'd0; rx_en = 1'b0;
    frame_hdr(1);
    word_out(32'h5C, 8, 1'b0, -1);
    rx_en = 1'b1;
    settle();
    chk("R11 traffic ignored while disabled", {31'h0, ready}, 32'h0);
    frame_hdr(1);
    word_out(32'h5C, 8, 1'b0, -1);
    settle();
    chk("R11 word received after enable", rdata, 32'h5C);
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk);
    chk("R11 disable clears ready", {31'h0, ready}, 32'h0);

    done = 1;
    summary();
  end

endmodule